// File: doc/BRIEF.md
# EDO DRAM Cycle Model

This block is a clock-sampled, synthesizable stand-in for an extended-data-output DRAM. It is meant to sit behind a memory controller under test. On each rising clock edge it samples the active-low row strobe, column strobe, write strobe and output enable, along with a multiplexed address and a write-data bus. It keeps a small word array, a row register and a column latch. Read data goes into a registered output latch, and a separate registered drive-enable tells the surrounding bench or pad logic when that latch is driving the bus.

The strobes are decoded from their sampled levels and from their levels one clock earlier. An edge is therefore seen in the first cycle that a new level is sampled. A row is "open" from the cycle after the row strobe is first sampled low until the row strobe is sampled high. The row-address and column-address fields both occupy the low bits of `addr`. The array word index is `{row, column}`, with the row in the upper bits.

Top module: `edo_dram_model`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `dout_en` is 0 and `dout` is 0.
- R2: The row address is captured from `addr[ROW_W-1:0]` in the cycle where `ras_n` is first sampled low. Later `addr` values do not change the row until the next such fall.
- R3: While `cas_n` is sampled high the column follows `addr[COL_W-1:0]`. The column closes in the cycle where `cas_n` is first sampled low. It then holds until `cas_n` rises, and `addr` changes meanwhile have no effect.
- R4: In a cycle with the row open, `cas_n` low and `we_n` high, the next cycle shows `dout` = array word `{row, column}` and `dout_en` = 1 if `oe_n` was low.
- R5: A cycle with `cas_n` sampled high gives `dout_en` = 0 in the next cycle.
- R6: `cas_n` falling while `ras_n` is high and has been high for a cycle neither drives nor reloads the output: `dout_en` stays 0.
- R7: `oe_n` high gives `dout_en` = 0 in the next cycle. It does not change the output latch: taking `oe_n` low again with the same column shows the same data.
- R8: `we_n` low while `cas_n` is low gives `dout_en` = 0 in the next cycle.
- R9: A write stores `din` at `{row, column}` in the cycle where both `cas_n` and `we_n` are low with the row open, and one of them was high one cycle earlier. This is the later of the two falls. The column used is the latched one.
- R10: If `ras_n` rises while `dout_en` is 1 and `cas_n` is low, the latched data stays on `dout`. `dout_en` then follows `oe_n`/`we_n` until `cas_n` goes high. If `dout_en` was 0 at the rise, the output stays off.
- R11: Every word of the `2**(ROW_W+COL_W)` array is independently writable and readable with page-mode cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered output latch |
| dout_en | output | 1 | Registered bus drive enable |

## Verification
The array is filled and read back with page-mode cycles over every row and column, using a pattern that differs per word. This exposes swapped or truncated index bits. A column that changes while the column strobe is high, followed by an address change after the fall, separates a flow-through latch from an edge-only latch or a fully transparent one. A read that turns into a write when the write strobe drops late separates the late-write rule from a write taken at the column fall. A row-strobe rise with the output driven, contrasted with one where the output is off, separates the output hold from a plain gate on the row strobe. Toggling output enable with the column held shows that the latch survives while the drive is off.

// File: rtl/edo_pkg.sv
package edo_pkg;
  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_strobes.sv
module edo_strobes (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic ras_q,
  output logic cas_q,
  output logic we_q,
  output logic row_fall,
  output logic row_rise,
  output logic row_open
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  assign row_fall = ras_q & ~ras_n;
  assign row_rise = ~ras_q & ras_n;
  assign row_open = ~ras_q & ~ras_n;
endmodule

// File: rtl/edo_addr_latch.sv
module edo_addr_latch #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_fall,
  input  logic              cas_q,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_cur
);
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (row_fall) row_q <= addr[ROW_W-1:0];
      if (cas_q)    col_q <= addr[COL_W-1:0];
    end
  end

  // flow-through while the column strobe was high, held once it has fallen
  assign col_cur = cas_q ? addr[COL_W-1:0] : col_q;
endmodule

// File: rtl/edo_array.sv
module edo_array #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= mem[idx];
  end
endmodule

// File: rtl/edo_out_ctrl.sv
module edo_out_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic row_open,
  input  logic row_rise,
  input  logic ras_n,
  input  logic ras_q,
  input  logic cas_n,
  input  logic cas_q,
  input  logic we_n,
  input  logic oe_n,
  output logic dout_en
);
  logic hold_q;
  logic hold_nx;

  assign hold_nx = ~cas_n & (hold_q | (row_rise & dout_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      hold_q  <= hold_nx & ras_n;
      dout_en <= ~oe_n & ~cas_n & we_n & (row_open | hold_nx);
    end
  end

  assert_cas_high_off_R5: assert property (@(posedge clk) disable iff (rst)
    cas_n |=> !dout_en);
  assert_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !dout_en);
  assert_we_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!we_n && !cas_n) |=> !dout_en);
  assert_cas_fall_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (ras_n && ras_q && !cas_n && cas_q) |=> !dout_en);
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = edo_pkg::max_w(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int IDX_W = ROW_W + COL_W;

  logic ras_q, cas_q, we_q;
  logic row_fall, row_rise, row_open;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_cur;
  logic path_on, wr_fire, rd_fire;

  edo_strobes u_strobes (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ras_q(ras_q), .cas_q(cas_q), .we_q(we_q),
    .row_fall(row_fall), .row_rise(row_rise), .row_open(row_open)
  );

  edo_addr_latch #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .row_fall(row_fall), .cas_q(cas_q), .addr(addr),
    .row_q(row_q), .col_cur(col_cur)
  );

  assign path_on = row_open & ~cas_n;
  assign wr_fire = path_on & ~we_n & (cas_q | we_q);
  assign rd_fire = path_on & we_n;

  edo_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst), .wr_en(wr_fire), .rd_en(rd_fire),
    .idx({row_q, col_cur}), .wdata(din), .rdata_q(dout)
  );

  edo_out_ctrl u_out (
    .clk(clk), .rst(rst), .row_open(row_open), .row_rise(row_rise),
    .ras_n(ras_n), .ras_q(ras_q), .cas_n(cas_n), .cas_q(cas_q),
    .we_n(we_n), .oe_n(oe_n), .dout_en(dout_en)
  );

  // output latch frozen while the row is closed
  assert_latch_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    ras_n |=> $stable(dout));
  // no write while the row strobe is high
  assert_no_write_closed_R9: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> !ras_n);
endmodule

// File: tb/test_edo_dram_model.sv
module test_edo_dram_model;
  localparam int ROW_W = 3;
  localparam int COL_W = 3;
  localparam int DW    = 8;
  localparam int AW    = 3;

  typedef struct {
    bit          ce;
    bit          ee;
    bit          cd;
    logic [DW-1:0] ed;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  exp_t q[$];
  logic [DW-1:0] model [64];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  edo_dram_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW)) i_edo_dram_model (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // monitor: 5 ns after each edge, compare against the queued item
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.ce) begin
        checks++;
        if (dout_en !== e.ee) begin
          fails++;
          $display("FAIL %s dout_en got %b exp %b", e.tag, dout_en, e.ee);
        end
      end
      if (e.cd) begin
        checks++;
        if (dout !== e.ed) begin
          fails++;
          $display("FAIL %s dout got %h exp %h", e.tag, dout, e.ed);
        end
      end
    end
  end

  task automatic step(input logic r, input logic c, input logic w, input logic o,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit ce, input bit ee, input bit cd,
                      input logic [DW-1:0] ed, input string tag);
    exp_t e;
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
    e.ce = ce; e.ee = ee; e.cd = cd; e.ed = ed; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [DW-1:0] pat(input int r, input int c);
    return DW'(r * 37 + c * 11 + 5);
  endfunction

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1 - 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(1,1,1,1,0,0, 1,0, 1,8'h00, "R1 reset");

    // R11 / R9 / R2: fill every word by page-mode early writes
    for (int r = 0; r < 8; r++) begin
      step(0,1,1,1,AW'(r),0, 1,0, 0,0, "R2 row open");
      for (int c = 0; c < 8; c++) begin
        step(0,1,0,1,AW'(c),pat(r,c), 1,0, 0,0, "R5 col setup");
        step(0,0,0,1,AW'(c),pat(r,c), 1,0, 0,0, "R8 write cycle");
        model[r*8+c] = pat(r,c);
        step(0,1,1,1,AW'(c),0, 1,0, 0,0, "R5 cas high");
      end
      step(1,1,1,1,0,0, 1,0, 0,0, "R5 idle");
    end

    // R11 / R4: read back every word
    for (int r = 0; r < 8; r++) begin
      step(0,1,1,0,AW'(r),0, 1,0, 0,0, "R2 row open");
      for (int c = 0; c < 8; c++) begin
        step(0,1,1,0,AW'(c),0, 1,0, 0,0, "R5 col setup");
        step(0,0,1,0,AW'(c),0, 1,1, 1,model[r*8+c], "R11 R4 readback");
        step(0,1,1,0,AW'(c),0, 1,0, 0,0, "R5 cas rise");
      end
      step(1,1,1,1,0,0, 1,0, 0,0, "R5 idle");
    end

    // R3 flow-through then closed column
    step(0,1,1,0,3'd4,0, 1,0, 0,0, "R2 row 4");
    step(0,1,1,0,3'd1,0, 1,0, 0,0, "R3 col 1");
    step(0,1,1,0,3'd6,0, 1,0, 0,0, "R3 col 6");
    step(0,0,1,0,3'd6,0, 1,1, 1,model[4*8+6], "R3 closes on fall");
    step(0,0,1,0,3'd2,0, 1,1, 1,model[4*8+6], "R3 addr ignored");
    step(0,1,1,0,3'd2,0, 1,0, 0,0, "R5 cas high");
    step(0,0,1,0,3'd2,0, 1,1, 1,model[4*8+2], "R3 new column");
    // R7 output enable toggling
    step(0,0,1,1,3'd2,0, 1,0, 0,0, "R7 oe high");
    step(0,0,1,0,3'd2,0, 1,1, 1,model[4*8+2], "R7 latch kept");
    step(1,1,1,1,0,0, 1,0, 0,0, "R5 idle");

    // R9 late write, R8 write strobe off
    step(0,1,1,0,3'd2,0, 1,0, 0,0, "R2 row 2");
    step(0,1,1,0,3'd5,0, 1,0, 0,0, "R3 col 5");
    step(0,0,1,0,3'd5,0, 1,1, 1,model[2*8+5], "R4 read before write");
    step(0,0,0,0,3'd1,8'hA5, 1,0, 0,0, "R8 we low");
    model[2*8+5] = 8'hA5;
    step(0,0,1,0,3'd1,0, 1,1, 1,8'hA5, "R9 late write data");
    step(0,1,1,0,3'd1,0, 1,0, 0,0, "R5 cas high");
    step(0,0,1,0,3'd1,0, 1,1, 1,model[2*8+1], "R9 neighbour untouched");
    step(1,1,1,1,0,0, 1,0, 0,0, "R5 idle");

    // R10 output hold over row strobe rise, R6
    step(0,1,1,0,3'd3,0, 1,0, 0,0, "R2 row 3");
    step(0,1,1,0,3'd3,0, 1,0, 0,0, "R3 col 3");
    step(0,0,1,0,3'd3,0, 1,1, 1,model[3*8+3], "R4 read");
    step(1,0,1,0,3'd0,0, 1,1, 1,model[3*8+3], "R10 hold at rise");
    step(1,0,1,0,3'd7,0, 1,1, 1,model[3*8+3], "R10 hold kept");
    step(1,0,1,1,3'd7,0, 1,0, 0,0, "R7 oe high in hold");
    step(1,0,1,0,3'd7,0, 1,1, 1,model[3*8+3], "R10 hold after oe");
    step(1,1,1,0,3'd7,0, 1,0, 0,0, "R10 ends on cas high");
    step(1,0,1,0,3'd7,0, 1,0, 1,model[3*8+3], "R6 cas fall row closed");
    step(1,1,1,1,0,0, 1,0, 0,0, "R5 idle");

    // R10 no hold when not driving at the rise
    step(0,1,1,1,3'd3,0, 1,0, 0,0, "R2 row 3");
    step(0,1,1,1,3'd4,0, 1,0, 0,0, "R3 col 4");
    step(0,0,1,1,3'd4,0, 1,0, 0,0, "R7 read oe high");
    step(1,0,1,0,3'd4,0, 1,0, 1,model[3*8+4], "R10 no hold");
    step(1,0,1,0,3'd4,0, 1,0, 0,0, "R10 still off");
    step(1,1,1,1,0,0, 1,0, 0,0, "R5 idle");

    step(1,1,1,1,0,0, 0,0, 0,0, "drain");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule